// File: doc/BRIEF.md
# Bounds Register Branch-Init Controller

This block keeps a small file of four pointer-bounds registers. Each register holds a 64-bit lower limit and a 64-bit upper limit. On every retired branch, the block decides whether the whole file returns to its unbounded initial state or stays as it is. The branch arrives already decoded. The descriptor gives the branch kind, a near/far flag, the opcode byte and an optional prefix byte with its valid flag. A near branch that does not carry the marker prefix byte 0xF2 wipes all four registers, unless the preserve control is set. Far transfers and the one-byte-displacement jump are never treated as wiping branches.

Bound writes arrive on their own port and are sized to the current operating mode. The block also holds a small configuration register that contains the preserve control. A separate combinational checker takes the operating mode and the address-size override prefix 0x67 for a bound instruction. From these it reports whether the instruction is undefined and which address width it uses.

Top module: `bnd_branch_ctrl`

## Requirements
- R1: After reset, every index reads lower 0 and upper all-ones, `init_pulse` is 0, and the preserve control is clear, so an unprefixed near branch wipes the file.
- R2: A near CALL/RET/JMP or conditional jump carrying prefix byte 0xF2 (`br_pfx_vld`=1, `br_pfx`=8'hF2) leaves all four registers unchanged.
- R3: With preserve clear, a near eligible branch without 0xF2 sets all four registers to lower 0 / upper all-ones at the next clock edge. A different prefix byte such as 0xF3 counts as no marker.
- R4: The preserve control is bit 1 of `cfg_wdata`, loaded when `cfg_wr`=1. While it is 1, no branch wipes the file, and the other configuration bits have no effect on this.
- R5: Branches with `br_far`=1, and a JMP (`br_kind`=2) with opcode 8'hEB, never wipe the file, even with preserve clear and no prefix.
- R6: A bound write (`wr_en`, `wr_idx`) stores the lower and upper values unchanged in 64-bit mode (`op_mode`=0). In 32-bit (1), compatibility (2) or 16-bit legacy (3) mode it clears bits 63:32 of both values.
- R7: When a bound write and a wiping branch occur in the same cycle, the wipe wins and the written index also reads the initial state.
- R8: `init_pulse` is 1 for exactly the one cycle after the clock edge at which a wipe happened, and 0 otherwise.
- R9: For memory forms (`ai_mem`=1), the address-size result depends on mode:
  - 64-bit mode: always 64-bit addressing, never undefined.
  - 32-bit and compatibility modes: undefined when 0x67 is present (`ai_pfx67`=1), otherwise 32-bit addressing.
  - 16-bit mode: 32-bit addressing when 0x67 is present, otherwise undefined.
- R10: For register-only forms (`ai_mem`=0), `ai_pfx67` is ignored. `ai_ud` is 0, and `ai_addr64` is 1 only in 64-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Load configuration register |
| cfg_wdata | input | 8 | Configuration value; bit 1 is preserve |
| op_mode | input | 2 | 0 64-bit, 1 32-bit, 2 compatibility, 3 16-bit legacy |
| wr_en | input | 1 | Bound write request |
| wr_idx | input | 2 | Register index written |
| wr_lo | input | 64 | Lower bound to write |
| wr_hi | input | 64 | Upper bound to write (true value) |
| rd_idx | input | 2 | Register index read |
| rd_lo | output | 64 | Lower bound of `rd_idx` |
| rd_hi | output | 64 | Upper bound of `rd_idx` (true value) |
| br_valid | input | 1 | A branch retires this cycle |
| br_kind | input | 2 | 0 CALL, 1 RET, 2 JMP, 3 conditional jump |
| br_far | input | 1 | Far transfer |
| br_opcode | input | 8 | Primary opcode byte |
| br_pfx_vld | input | 1 | A prefix byte accompanies the branch |
| br_pfx | input | 8 | The prefix byte |
| init_pulse | output | 1 | One-cycle flag after a wipe |
| ai_mem | input | 1 | Bound instruction has a memory operand |
| ai_pfx67 | input | 1 | Address-size override present |
| ai_ud | output | 1 | Instruction is undefined |
| ai_addr64 | output | 1 | 64-bit addressing (else 32-bit) |

## Verification
The bench targets the exemptions.

- **Short jump:** a design that only tests `br_far` would wipe the file on the 0xEB short jump. That wipe shows up on the read port and as a stray `init_pulse`.
- **Wrong prefix byte:** a near branch carrying 0xF3 must still wipe. A decoder that accepted any prefix as the marker would keep stale bounds.
- **Configuration bits:** bit 1 is exercised both alone and with every other configuration bit set, so a preserve decode from the wrong bit position is caught.
- **Write and wipe in one cycle:** this collision is driven, and a write-first priority leaves the new value behind.
- **32-bit writes:** these use values with non-zero high halves, so a missing truncation leaks the upper 32 bits.

// File: rtl/bnd_ctl_pkg.sv
package bnd_ctl_pkg;

    localparam int BND_W        = 64;
    localparam int NUM_BND      = 4;
    localparam int IDX_W        = $clog2(NUM_BND);
    localparam int CFG_W        = 8;
    localparam int PRESERVE_BIT = 1;
    localparam int NARROW_W     = 32;
    localparam logic [7:0] MARK_PFX     = 8'hF2;
    localparam logic [7:0] SHORT_JMP_OP = 8'hEB;

    typedef enum logic [1:0] {
        BK_CALL = 2'd0,
        BK_RET  = 2'd1,
        BK_JMP  = 2'd2,
        BK_JCC  = 2'd3
    } br_kind_e;

    typedef enum logic [1:0] {
        OM_LONG64 = 2'd0,
        OM_PROT32 = 2'd1,
        OM_COMPAT = 2'd2,
        OM_REAL16 = 2'd3
    } op_mode_e;

    // Upper limit kept inverted so the all-zero word is the unbounded state.
    typedef struct packed {
        logic [BND_W-1:0] lo;
        logic [BND_W-1:0] hi_n;
    } bnd_entry_t;

    typedef struct packed {
        logic       valid;
        br_kind_e   kind;
        logic       far;
        logic [7:0] opcode;
        logic       pfx_vld;
        logic [7:0] pfx;
    } br_desc_t;

    function automatic logic [BND_W-1:0] size_operand(logic [BND_W-1:0] v, op_mode_e m);
        if (m == OM_LONG64) return v;
        return {{(BND_W-NARROW_W){1'b0}}, v[NARROW_W-1:0]};
    endfunction

    function automatic logic never_wipes(br_desc_t d);
        return d.far || (d.kind == BK_JMP && d.opcode == SHORT_JMP_OP);
    endfunction

endpackage

// File: rtl/bnd_init_decide.sv
module bnd_init_decide
    import bnd_ctl_pkg::*;
(
    input  br_desc_t desc_i,
    input  logic     preserve_i,
    output logic     wipe_o
);
    logic marked;

    always_comb begin
        marked = desc_i.pfx_vld && (desc_i.pfx == MARK_PFX);
        wipe_o = desc_i.valid && !never_wipes(desc_i) && !marked && !preserve_i;
    end
endmodule

// File: rtl/bnd_file.sv
module bnd_file
    import bnd_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wipe_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [BND_W-1:0] wr_lo_i,
    input  logic [BND_W-1:0] wr_hi_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [BND_W-1:0] rd_lo_o,
    output logic [BND_W-1:0] rd_hi_o
);
    bnd_entry_t ents [NUM_BND];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_BND; i++) begin
            if (rst || wipe_i)
                ents[i] <= '0;
            else if (wr_en_i && wr_idx_i == IDX_W'(i))
                ents[i] <= '{lo: wr_lo_i, hi_n: ~wr_hi_i};
        end
    end

    always_comb begin
        rd_lo_o = ents[rd_idx_i].lo;
        rd_hi_o = ~ents[rd_idx_i].hi_n;
    end

    for (genvar g = 0; g < NUM_BND; g++) begin : g_chk
        p_wipe_clears_r3: assert property (@(posedge clk) disable iff (rst)
            wipe_i |=> (ents[g] == '0));
        p_idle_holds_r2: assert property (@(posedge clk) disable iff (rst)
            (!wipe_i && !(wr_en_i && wr_idx_i == IDX_W'(g))) |=> $stable(ents[g]));
    end
endmodule

// File: rtl/bnd_addr_chk.sv
module bnd_addr_chk
    import bnd_ctl_pkg::*;
(
    input  op_mode_e mode_i,
    input  logic     is_mem_i,
    input  logic     pfx67_i,
    output logic     ud_o,
    output logic     addr64_o
);
    always_comb begin
        ud_o     = 1'b0;
        addr64_o = (mode_i == OM_LONG64);
        if (is_mem_i) begin
            unique case (mode_i)
                OM_LONG64:            ud_o = 1'b0;
                OM_PROT32, OM_COMPAT: ud_o = pfx67_i;
                OM_REAL16:            ud_o = !pfx67_i;
                default:              ud_o = 1'b0;
            endcase
        end
    end

    always_comb begin
        p_no_ud_in_long_r9: assert (!(ud_o && addr64_o));
        if (!is_mem_i)
            p_regform_defined_r10: assert (!ud_o);
    end
endmodule

// File: rtl/bnd_branch_ctrl.sv
module bnd_branch_ctrl
    import bnd_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [1:0]       op_mode,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [BND_W-1:0] wr_lo,
    input  logic [BND_W-1:0] wr_hi,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [BND_W-1:0] rd_lo,
    output logic [BND_W-1:0] rd_hi,
    input  logic             br_valid,
    input  logic [1:0]       br_kind,
    input  logic             br_far,
    input  logic [7:0]       br_opcode,
    input  logic             br_pfx_vld,
    input  logic [7:0]       br_pfx,
    output logic             init_pulse,
    input  logic             ai_mem,
    input  logic             ai_pfx67,
    output logic             ai_ud,
    output logic             ai_addr64
);
    logic [CFG_W-1:0] cfg_q;
    logic             wipe;
    br_desc_t         desc;
    op_mode_e         mode;
    logic [BND_W-1:0] lo_sized;
    logic [BND_W-1:0] hi_sized;

    always_comb begin
        mode     = op_mode_e'(op_mode);
        desc     = '{valid: br_valid, kind: br_kind_e'(br_kind), far: br_far,
                     opcode: br_opcode, pfx_vld: br_pfx_vld, pfx: br_pfx};
        lo_sized = size_operand(wr_lo, mode);
        hi_sized = size_operand(wr_hi, mode);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= '0;
            init_pulse <= 1'b0;
        end else begin
            if (cfg_wr) cfg_q <= cfg_wdata;
            init_pulse <= wipe;
        end
    end

    bnd_init_decide u_decide (
        .desc_i     (desc),
        .preserve_i (cfg_q[PRESERVE_BIT]),
        .wipe_o     (wipe)
    );

    bnd_file u_file (
        .clk      (clk),
        .rst      (rst),
        .wipe_i   (wipe),
        .wr_en_i  (wr_en),
        .wr_idx_i (wr_idx),
        .wr_lo_i  (lo_sized),
        .wr_hi_i  (hi_sized),
        .rd_idx_i (rd_idx),
        .rd_lo_o  (rd_lo),
        .rd_hi_o  (rd_hi)
    );

    bnd_addr_chk u_addr (
        .mode_i   (mode),
        .is_mem_i (ai_mem),
        .pfx67_i  (ai_pfx67),
        .ud_o     (ai_ud),
        .addr64_o (ai_addr64)
    );

    p_pulse_has_cause_r8: assert property (@(posedge clk) disable iff (rst)
        init_pulse |-> $past(br_valid));
    p_far_exempt_r5: assert property (@(posedge clk) disable iff (rst)
        (br_valid && br_far) |=> !init_pulse);
    p_marker_keeps_r2: assert property (@(posedge clk) disable iff (rst)
        (br_valid && br_pfx_vld && br_pfx == MARK_PFX) |=> !init_pulse);
    p_preserve_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        cfg_q[PRESERVE_BIT] |=> !init_pulse);
    p_cfg_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> $stable(cfg_q));
endmodule

// File: tb/tb_bnd_branch_ctrl.sv
module tb_bnd_branch_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [7:0]  cfg_wdata;
    logic [1:0]  op_mode;
    logic        wr_en;
    logic [1:0]  wr_idx;
    logic [63:0] wr_lo, wr_hi;
    logic [1:0]  rd_idx;
    logic [63:0] rd_lo, rd_hi;
    logic        br_valid;
    logic [1:0]  br_kind;
    logic        br_far;
    logic [7:0]  br_opcode;
    logic        br_pfx_vld;
    logic [7:0]  br_pfx;
    logic        init_pulse;
    logic        ai_mem, ai_pfx67, ai_ud, ai_addr64;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        string       req;
        logic        pulse;
        int          idx;
        logic [63:0] lo;
        logic [63:0] hi;
    } exp_t;
    exp_t q[$];

    logic [63:0] m_lo [4];
    logic [63:0] m_hi [4];
    logic        m_pres;

    always #4 clk = ~clk;

    bnd_branch_ctrl dut (.*);

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Monitor: pops the expectation for this edge and compares.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            rd_idx = 2'(e.idx);
            #1;
            checks++;
            if (init_pulse !== e.pulse || rd_lo !== e.lo || rd_hi !== e.hi) begin
                errors++;
                $display("FAIL %s idx%0d: actual pulse=%b lo=%h hi=%h expected pulse=%b lo=%h hi=%h",
                         e.req, e.idx, init_pulse, rd_lo, rd_hi, e.pulse, e.lo, e.hi);
            end
        end
    end

    function automatic logic [63:0] szd(logic [63:0] v, logic [1:0] m);
        return (m == 2'd0) ? v : {32'h0, v[31:0]};
    endfunction

    task automatic step(string req, logic w, logic [1:0] wi, logic [63:0] lo, logic [63:0] hi,
                        logic [1:0] md, logic bv, logic [1:0] bk, logic bf, logic [7:0] op,
                        logic pv, logic [7:0] pb, logic cw, logic [7:0] cd, int ci);
        logic wipe;
        exp_t e;
        @(negedge clk);
        wr_en = w; wr_idx = wi; wr_lo = lo; wr_hi = hi; op_mode = md;
        br_valid = bv; br_kind = bk; br_far = bf; br_opcode = op;
        br_pfx_vld = pv; br_pfx = pb; cfg_wr = cw; cfg_wdata = cd;
        wipe = bv && !bf && !(bk == 2'd2 && op == 8'hEB) && !(pv && pb == 8'hF2) && !m_pres;
        if (wipe) begin
            for (int i = 0; i < 4; i++) begin m_lo[i] = '0; m_hi[i] = '1; end
        end else if (w) begin
            m_lo[wi] = szd(lo, md); m_hi[wi] = szd(hi, md);
        end
        if (cw) m_pres = cd[1];
        e = '{req: req, pulse: wipe, idx: ci, lo: m_lo[ci], hi: m_hi[ci]};
        q.push_back(e);
        @(posedge clk);
    endtask

    task automatic idle_all(string req);
        for (int i = 0; i < 4; i++)
            step(req, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, i);
    endtask

    task automatic br(string req, logic [1:0] k, logic f, logic [7:0] op, logic pv, logic [7:0] pb);
        step(req, 0, 0, 0, 0, 0, 1, k, f, op, pv, pb, 0, 0, 0);
        idle_all(req);
    endtask

    task automatic fill(string req);
        step(req, 1, 0, 64'h0000_0000_0000_1000, 64'h0000_7FFF_0000_2000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step(req, 1, 1, 64'hAAAA_0000_0000_0040, 64'hBBBB_0000_0000_0800, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        step(req, 1, 2, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 1, 0, 0, 0, 0, 0, 0, 0, 0, 2);
        step(req, 1, 3, 64'hDEAD_BEEF_0000_0100, 64'hFEED_FACE_0000_0F00, 2, 0, 0, 0, 0, 0, 0, 0, 0, 3);
        idle_all(req);
    endtask

    task automatic addr(logic [1:0] md, logic mem, logic p, logic eud, logic ea64, string req);
        @(negedge clk);
        op_mode = md; ai_mem = mem; ai_pfx67 = p;
        #1;
        checks++;
        if (ai_ud !== eud || ai_addr64 !== ea64) begin
            errors++;
            $display("FAIL %s mode=%0d mem=%b pfx=%b: actual ud=%b a64=%b expected ud=%b a64=%b",
                     req, md, mem, p, ai_ud, ai_addr64, eud, ea64);
        end
    endtask

    initial begin
        rst = 1; cfg_wr = 0; cfg_wdata = 0; op_mode = 0; wr_en = 0; wr_idx = 0;
        wr_lo = 0; wr_hi = 0; rd_idx = 0; br_valid = 0; br_kind = 0; br_far = 0;
        br_opcode = 0; br_pfx_vld = 0; br_pfx = 0; ai_mem = 0; ai_pfx67 = 0;
        for (int i = 0; i < 4; i++) begin m_lo[i] = '0; m_hi[i] = '1; end
        m_pres = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        idle_all("R1 reset state");
        fill("R6 sized writes");
        step("R6 16-bit write", 1, 0, 64'hCAFE_0000_1234_5678, 64'h0F0F_0000_9ABC_DEF0, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        br("R2 marked CALL", 2'd0, 0, 8'hE8, 1, 8'hF2);
        br("R2 marked RET", 2'd1, 0, 8'hC3, 1, 8'hF2);
        br("R2 marked JMP", 2'd2, 0, 8'hE9, 1, 8'hF2);
        br("R2 marked JCC", 2'd3, 0, 8'h75, 1, 8'hF2);

        br("R5 far CALL", 2'd0, 1, 8'h9A, 0, 0);
        br("R5 far RET", 2'd1, 1, 8'hCB, 0, 0);
        br("R5 far JMP", 2'd2, 1, 8'hEA, 0, 0);
        br("R5 short JMP EB", 2'd2, 0, 8'hEB, 0, 0);

        br("R3 R8 plain JCC wipes", 2'd3, 0, 8'h74, 0, 0);
        // R1: the wipe above also shows preserve was clear out of reset.
        fill("R3 refill");
        br("R3 F3 prefix still wipes", 2'd2, 0, 8'hE9, 1, 8'hF3);

        fill("R4 refill");
        step("R4 set preserve", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h02, 0);
        br("R4 plain CALL kept", 2'd0, 0, 8'hE8, 0, 0);
        br("R4 marked RET kept", 2'd1, 0, 8'hC3, 1, 8'hF2);
        step("R4 other bits only", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'hFD, 0);
        br("R4 plain JMP wipes with bit1 clear", 2'd2, 0, 8'hE9, 0, 0);

        fill("R7 refill");
        step("R7 write vs wipe", 1, 1, 64'h1234, 64'h5678, 0, 1, 2'd1, 0, 8'hC3, 0, 0, 0, 0, 1);
        idle_all("R7 R8 after collision");

        addr(0, 1, 0, 0, 1, "R9 64 no pfx");
        addr(0, 1, 1, 0, 1, "R9 64 pfx");
        addr(1, 1, 1, 1, 0, "R9 32 pfx");
        addr(1, 1, 0, 0, 0, "R9 32 no pfx");
        addr(2, 1, 1, 1, 0, "R9 compat pfx");
        addr(2, 1, 0, 0, 0, "R9 compat no pfx");
        addr(3, 1, 1, 0, 0, "R9 16 pfx");
        addr(3, 1, 0, 1, 0, "R9 16 no pfx");
        addr(3, 0, 0, 0, 0, "R10 16 reg form");
        addr(1, 0, 1, 0, 0, "R10 32 reg form");
        addr(0, 0, 1, 0, 1, "R10 64 reg form");

        repeat (3) @(posedge clk);
        if (q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d pending, expected 0", q.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule